// File: doc/BRIEF.md
# Poly1305 Dual-Lane Accumulate-and-Multiply Stage

This block performs the repeating step of a Poly1305 authenticator. Each accepted input carries a 128-bit message block and a 130-bit power of the key r. The block adds the message block to one of two stored accumulators and reduces the sum modulo p = 2^130-5. It then multiplies that sum by the supplied r power and reduces the product modulo p. The reduced product is emitted and also written back into the accumulator it came from. A per-input clear flag starts a fresh chain. When the flag is set, the block uses zero in place of the stored accumulator.

The two accumulators are used in strict alternation. The first accepted input after reset goes to lane 0, the next goes to lane 1, and so on. This lets two independent message streams share one datapath. Lane selection is implicit, so the caller must present blocks in interleaved order.

The control is a five-state machine:
- ST_IDLE: accepts an input when in_valid is high.
- ST_SUM: forms and reduces the sum.
- ST_MUL: forms the 260-bit product.
- ST_FOLD: performs the first fold, which multiplies the upper bits by 5 and adds them in.
- ST_EMIT: performs the second fold and the final subtraction, writes the accumulator and raises out_valid.

The transitions are:
- accept: ST_IDLE to ST_SUM, taken when in_valid is high.
- ST_SUM to ST_MUL, ST_MUL to ST_FOLD and ST_FOLD to ST_EMIT, each taken unconditionally.
- finish: ST_EMIT to ST_IDLE.

Any other state encoding returns to ST_IDLE.

Top module: `poly1305_accmul_stage`

## Requirements
- R1: A result equals ((block + acc) mod p) × rpow mod p, where acc is the selected lane's stored value and p = 2^130-5. The result replaces that lane's stored value.
- R2: Every sum and every result is fully reduced into 0..p-1. This holds even when block + acc equals p exactly, and for block = 2^128-1 with rpow = p-1.
- R3: When in_clear is 1 on an accepted input, the stored value of the selected lane is not used. The result is (block mod p) × rpow mod p, and it overwrites that lane.
- R4: Lane selection starts at lane 0 after reset and toggles on every accepted input, whatever the clear flag.
- R5: An input is accepted only on a rising edge where in_valid and in_ready are both 1. While in_ready is 0, in_valid and the data inputs have no effect.
- R6: out_valid is 1 for exactly one cycle per result. It rises in the cycle after the fifth rising edge counted from the accepting edge, which is 5 cycles of latency.
- R7: in_ready is 0 for the four cycles after an accepting edge, and it is 1 again in the cycle where out_valid is 1.
- R8: A synchronous active-high rst clears both lanes to zero and the lane selector to lane 0. During and after rst, in_ready is 1 and out_valid is 0.
- R9: Results leave in acceptance order, with exactly one result per accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input offer |
| in_ready | output | 1 | Stage idle and able to accept |
| in_clear | input | 1 | Ignore stored lane value for this input |
| in_block | input | 128 | Message block |
| in_rpow | input | 130 | Key power, 0..p-1 |
| out_valid | output | 1 | One-cycle result strobe |
| out_value | output | 130 | Reduced result |

## Verification
The bench drives an accumulator chain to exactly p-1 and then adds 1, so the sum lands exactly on p. A missing or misplaced subtraction would then emit p or garbage instead of 0. The bench also uses maximal blocks with rpow = p-1, which would expose a single fold that leaves the result above p. A lane-swap case uses values that give different results depending on which lane is read, so a selector that fails to toggle, or toggles on the wrong event, produces a mismatch. The same applies to a reset that leaves the selector or the lanes dirty. Junk data, and in_valid pulses that end while the stage is busy, would cause extra results or corrupted lanes if they were wrongly accepted. Per-cycle checks of in_ready and out_valid catch a latency or strobe-width error.

// File: rtl/poly_stage_pkg.sv
package poly_stage_pkg;

    parameter int unsigned DEF_ELEM_W = 130;
    parameter int unsigned DEF_MSG_W  = 128;
    parameter int unsigned DEF_FOLD_K = 5;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SUM  = 3'd1,
        ST_MUL  = 3'd2,
        ST_FOLD = 3'd3,
        ST_EMIT = 3'd4
    } stage_state_e;

endpackage

// File: rtl/poly_fold.sv
// One pseudo-Mersenne fold: y = x[low] + x[high] * FOLD_K
module poly_fold #(
    parameter int unsigned ELEM_W = 130,
    parameter int unsigned IN_W   = 260,
    parameter int unsigned OUT_W  = 134,
    parameter int unsigned FOLD_K = 5
) (
    input  logic [IN_W-1:0]  x,
    output logic [OUT_W-1:0] y
);
    localparam int unsigned KW   = $clog2(FOLD_K) + 1;
    localparam int unsigned HI_W = IN_W - ELEM_W;

    logic [HI_W+KW-1:0] hi_scaled;

    assign hi_scaled = (HI_W+KW)'(x[IN_W-1:ELEM_W]) * (HI_W+KW)'(FOLD_K);
    assign y         = OUT_W'(x[ELEM_W-1:0]) + OUT_W'(hi_scaled);

endmodule

// File: rtl/poly_csub.sv
// Conditional subtraction of the prime; valid for inputs below 2p
module poly_csub #(
    parameter int unsigned ELEM_W = 130,
    parameter int unsigned IN_W   = 131,
    parameter int unsigned FOLD_K = 5
) (
    input  logic [IN_W-1:0]   x,
    output logic [ELEM_W-1:0] y
);
    localparam logic [IN_W-1:0] PRIME_X =
        IN_W'({ELEM_W{1'b1}}) - IN_W'(FOLD_K - 1);

    logic [IN_W-1:0] diff;

    assign diff = x - PRIME_X;
    assign y    = (x >= PRIME_X) ? diff[ELEM_W-1:0] : x[ELEM_W-1:0];

endmodule

// File: rtl/poly1305_accmul_stage.sv
module poly1305_accmul_stage
    import poly_stage_pkg::*;
#(
    parameter int unsigned ELEM_W = DEF_ELEM_W,
    parameter int unsigned MSG_W  = DEF_MSG_W,
    parameter int unsigned FOLD_K = DEF_FOLD_K
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_clear,
    input  logic [MSG_W-1:0]  in_block,
    input  logic [ELEM_W-1:0] in_rpow,
    output logic              out_valid,
    output logic [ELEM_W-1:0] out_value
);
    localparam int unsigned KW     = $clog2(FOLD_K) + 1;
    localparam int unsigned SUM_W  = ELEM_W + 1;
    localparam int unsigned PROD_W = 2 * ELEM_W;
    localparam int unsigned HI1_W  = PROD_W - ELEM_W;
    localparam int unsigned F1_W   = ((HI1_W + KW) > ELEM_W ? (HI1_W + KW) : ELEM_W) + 1;
    localparam int unsigned HI2_W  = F1_W - ELEM_W;
    localparam int unsigned F2_W   = ((HI2_W + KW) > ELEM_W ? (HI2_W + KW) : ELEM_W) + 1;
    localparam int unsigned LANES  = 2;
    localparam logic [ELEM_W-1:0] PRIME = {ELEM_W{1'b1}} - ELEM_W'(FOLD_K - 1);

    stage_state_e state_q, state_d;

    logic              sel_q;
    logic              cur_q;
    logic              clr_q;
    logic [MSG_W-1:0]  blk_q;
    logic [ELEM_W-1:0] rpow_q;
    logic [ELEM_W-1:0] acc_q [LANES];
    logic [ELEM_W-1:0] sum_q;
    logic [PROD_W-1:0] prod_q;
    logic [F1_W-1:0]   fold_q;
    logic              out_valid_q;
    logic [ELEM_W-1:0] out_value_q;

    logic              accept;
    logic [ELEM_W-1:0] acc_pick;
    logic [SUM_W-1:0]  sum_raw;
    logic [ELEM_W-1:0] sum_red;
    logic [F1_W-1:0]   fold1_y;
    logic [F2_W-1:0]   fold2_y;
    logic [ELEM_W-1:0] final_red;

    assign accept = in_valid && (state_q == ST_IDLE);

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_SUM;
            ST_SUM:  state_d = ST_MUL;
            ST_MUL:  state_d = ST_FOLD;
            ST_FOLD: state_d = ST_EMIT;
            ST_EMIT: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- arithmetic ----------------
    assign acc_pick = clr_q ? '0 : acc_q[cur_q];
    assign sum_raw  = SUM_W'(acc_pick) + SUM_W'(blk_q);

    poly_csub #(.ELEM_W(ELEM_W), .IN_W(SUM_W), .FOLD_K(FOLD_K)) u_sum_red (
        .x (sum_raw),
        .y (sum_red)
    );

    poly_fold #(.ELEM_W(ELEM_W), .IN_W(PROD_W), .OUT_W(F1_W), .FOLD_K(FOLD_K)) u_fold1 (
        .x (prod_q),
        .y (fold1_y)
    );

    poly_fold #(.ELEM_W(ELEM_W), .IN_W(F1_W), .OUT_W(F2_W), .FOLD_K(FOLD_K)) u_fold2 (
        .x (fold_q),
        .y (fold2_y)
    );

    poly_csub #(.ELEM_W(ELEM_W), .IN_W(F2_W), .FOLD_K(FOLD_K)) u_final_red (
        .x (fold2_y),
        .y (final_red)
    );

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q       <= 1'b0;
            cur_q       <= 1'b0;
            clr_q       <= 1'b0;
            blk_q       <= '0;
            rpow_q      <= '0;
            sum_q       <= '0;
            prod_q      <= '0;
            fold_q      <= '0;
            out_valid_q <= 1'b0;
            out_value_q <= '0;
            for (int i = 0; i < LANES; i++) acc_q[i] <= '0;
        end else begin
            out_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        blk_q  <= in_block;
                        rpow_q <= in_rpow;
                        clr_q  <= in_clear;
                        cur_q  <= sel_q;
                        sel_q  <= ~sel_q;
                    end
                end
                ST_SUM:  sum_q  <= sum_red;
                ST_MUL:  prod_q <= PROD_W'(sum_q) * PROD_W'(rpow_q);
                ST_FOLD: fold_q <= fold1_y;
                ST_EMIT: begin
                    acc_q[cur_q] <= final_red;
                    out_value_q  <= final_red;
                    out_valid_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign in_ready  = (state_q == ST_IDLE);
    assign out_valid = out_valid_q;
    assign out_value = out_value_q;

    // ---------------- assertions ----------------
    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);                                            // R7
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);                                        // R6
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(accept, 5));                                  // R6
    AST_RESULT_REDUCED: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_value < PRIME));                               // R2
    AST_SUM_REDUCED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MUL) |-> (sum_q < PRIME));                         // R2
    AST_LANE_FLIP: assert property (@(posedge clk) disable iff (rst)
        accept |=> (sel_q != $past(sel_q)));                              // R4
    AST_READY_AT_RESULT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> in_ready);                                          // R7

endmodule

// File: tb/poly1305_accmul_stage_tb_top.sv
`timescale 1ns/1ps
module poly1305_accmul_stage_tb_top;

    localparam logic [129:0] P = {130{1'b1}} - 130'd4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_clear = 1'b0;
    logic [127:0] in_block = '0;
    logic [129:0] in_rpow  = '0;
    logic         out_valid;
    logic [129:0] out_value;

    int n_cmp = 0;
    int n_bad = 0;
    int n_out = 0;
    int n_sent = 0;

    logic [129:0] exp_q [$];
    string        tag_q [$];
    logic [129:0] mdl_acc [2];
    logic         mdl_sel;

    always #5 clk = ~clk;

    poly1305_accmul_stage dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_clear  (in_clear),
        .in_block  (in_block),
        .in_rpow   (in_rpow),
        .out_valid (out_valid),
        .out_value (out_value)
    );

    task automatic chk(input logic ok, input string tag, input logic [129:0] act, input logic [129:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [129:0] model(input logic [127:0] m, input logic [129:0] a,
                                           input logic [129:0] r, input logic c);
        logic [259:0] s, t;
        s = 260'(m) + (c ? 260'd0 : 260'(a));
        s = s % 260'(P);
        t = s * 260'(r);
        t = t % 260'(P);
        return t[129:0];
    endfunction

    function automatic logic [129:0] rnd130();
        logic [159:0] w;
        w = {$urandom, $urandom, $urandom, $urandom, $urandom};
        return (w[129:0] >= P) ? (w[129:0] - P) : w[129:0];
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(in_ready === 1'b1 && out_valid === 1'b0, "R8 reset outputs",
            {128'd0, out_valid, in_ready}, 130'd1);
        rst = 1'b0;
        mdl_acc[0] = '0;
        mdl_acc[1] = '0;
        mdl_sel = 1'b0;
    endtask

    // driver: offers one input, pushes the expected result, checks handshake timing
    task automatic send(input logic [127:0] m, input logic [129:0] r, input logic c,
                        input string tag, input logic poke);
        logic [129:0] e;
        @(negedge clk);
        in_valid = 1'b1;
        in_block = m;
        in_rpow  = r;
        in_clear = c;
        while (!in_ready) @(negedge clk);
        e = model(m, mdl_acc[mdl_sel], r, c);
        mdl_acc[mdl_sel] = e;
        mdl_sel = ~mdl_sel;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        n_sent++;
        @(negedge clk);
        // junk while busy; R5: must be ignored
        in_valid = poke;
        in_block = rnd128();
        in_rpow  = rnd130();
        in_clear = $urandom_range(0, 1);
        chk(in_ready === 1'b0, "R7 busy after accept", {129'd0, in_ready}, 130'd0);
        for (int i = 2; i <= 4; i++) begin
            @(negedge clk);
            chk(in_ready === 1'b0, "R7 busy during compute", {129'd0, in_ready}, 130'd0);
            if (i == 4) in_valid = 1'b0;
        end
        @(negedge clk);
        chk(out_valid === 1'b1 && in_ready === 1'b1, "R6 result strobe at latency 5",
            {128'd0, out_valid, in_ready}, 130'd3);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_out++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected extra result", out_value, '0);
            end else begin
                logic [129:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(out_value === e, t, out_value, e);
            end
        end
    end

    initial begin
        mdl_acc[0] = '0;
        mdl_acc[1] = '0;
        mdl_sel = 1'b0;
        repeat (3) @(negedge clk);
        do_reset();

        send(128'd5, 130'd3, 1'b0, "R8 fresh lane0 is zero", 1'b0);
        send(128'd7, 130'd2, 1'b0, "R4 second input uses lane1", 1'b1);
        send(128'd1, 130'd1, 1'b0, "R1 lane0 accumulates", 1'b0);
        send(128'd1, P - 130'd1, 1'b1, "R3 clear ignores lane1", 1'b0);
        send(128'd0, 130'd0, 1'b1, "R3 clear with zero inputs", 1'b1);
        send(128'd1, 130'd1, 1'b0, "R2 sum exactly p reduces to 0", 1'b0);
        send({128{1'b1}}, P - 130'd1, 1'b0, "R2 max block times p-1", 1'b0);
        send({128{1'b1}}, P - 130'd1, 1'b1, "R2 max block cleared", 1'b1);
        send(128'd3, 130'd11, 1'b0, "R4 lane0 after clear toggle", 1'b0);

        // idle junk without valid: R5
        @(negedge clk);
        in_valid = 1'b0;
        in_block = rnd128();
        in_rpow  = rnd130();
        repeat (4) @(negedge clk);
        chk(out_valid === 1'b0, "R5 no result without valid", {129'd0, out_valid}, 130'd0);

        do_reset();
        send(128'd9, 130'd9, 1'b0, "R8 lane0 cleared by reset", 1'b0);
        send(128'd2, 130'd2, 1'b0, "R8 lane1 cleared by reset", 1'b0);

        for (int k = 0; k < 300; k++) begin
            int stall;
            stall = $urandom_range(0, 3);
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_block = rnd128();
            end
            send(rnd128(), rnd130(), ($urandom_range(0, 10) == 0), "R1 random chain",
                 $urandom_range(0, 1));
        end

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0 && n_out == n_sent, "R9 one result per input",
            130'(n_out), 130'(n_sent));
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL R9 watchdog expired: actual %0d results expected %0d", n_out, n_sent);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule